// File: doc/BRIEF.md
# Programmable Sensor Frame Timing Generator

This block produces the raster timing of an image sensor readout: a frame-valid window, a line-valid strobe for each active row, a one-cycle frame-start marker, and the row and column position of the scan. It runs on the master clock and also emits a pixel-clock enable, high on every other master cycle. All timing is counted in column units. A column unit lasts `cfg_mult + 2` master clocks, so with a multiplier of 0 one unit equals one pixel clock.

A row starts with its blanking stretch and ends with its active columns. The blanking length is a fixed overhead plus the programmed horizontal blanking. The dark-column mode selects the overhead: 107 units with no dark columns, 113 units with eight, and 121 units with sixteen. A frame holds the active rows, the programmed vertical blanking rows and one more row. If the integration row count reaches that total, the frame is stretched to `integ + 1` rows. Frame-valid opens 6 units before the first active column and closes 6 units after the last one. For example, a 640×480 setup with horizontal blanking 131, vertical blanking 28, multiplier 0 and eight dark columns gives an 884-pixel-clock row and a 449,956-pixel-clock frame. Of that frame, 25,868 pixel clocks lie outside frame-valid.

The configuration ports are static inputs. They are captured while reset is held, and again on the last master cycle of each frame. A change made during a frame therefore applies only from the next frame on.

Top module: `frame_timing_gen`

## Requirements
- R1: While `rst_n` is low, `frame_valid`, `line_valid`, `frame_start`, `pclk_en`, `row_cnt` and `col_cnt` are all 0.
- R2: `pclk_en` inverts on every master clock edge after reset is released, so it reads 1, 0, 1, 0 in the cycles that follow release.
- R3: One column unit lasts `cfg_mult + 2` master clocks. A row lasts `(cfg_cols + 1) + Q` units, where Q is the blanking length and the active columns come last.
- R4: The overhead in Q is set by `cfg_dark`: 2'b00 gives 107, 2'b01 gives 113, and 2'b10 or 2'b11 give 121.
- R5: Q equals the overhead plus `cfg_hblank`, except that a `cfg_hblank` below 9 is used as 9.
- R6: Let S = `cfg_rows + cfg_vblank + 2`. A frame has S rows when `cfg_integ` < S, and `cfg_integ + 1` rows otherwise.
- R7: `frame_valid` rises (Q − 6) units into row 0 and falls 6 units into row `cfg_rows + 1`. It is therefore high for `(cfg_rows + 1) × rowlength − Q + 12` units per frame.
- R8: `line_valid` is high exactly during the active columns of rows 0 to `cfg_rows`. This gives `cfg_rows + 1` line pulses per frame, and `line_valid` is never high while `frame_valid` is low.
- R9: `frame_start` is high for exactly one master cycle per frame: the cycle in which `frame_valid` rises, which is (Q − 6) × (`cfg_mult` + 2) cycles after the frame begins.
- R10: The configuration is captured only during reset and on the last cycle of a frame. Input changes made during a frame leave that frame's timing unchanged.
- R11: `col_cnt` is the unit index within the row and `row_cnt` is the row index within the frame. `col_cnt` runs from 0 to rowlength − 1 and `row_cnt` runs from 0 to frame rows − 1. A frame begins when both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cols | input | COL_W | Active column count minus one |
| cfg_rows | input | ROW_W | Active row count minus one |
| cfg_hblank | input | HB_W | Programmed horizontal blanking, in units |
| cfg_vblank | input | VB_W | Programmed vertical blanking, in rows |
| cfg_mult | input | MULT_W | Unit length minus two, in master clocks |
| cfg_dark | input | 2 | Dark-column mode selecting the blanking overhead |
| cfg_integ | input | INT_W | Integration row count |
| pclk_en | output | 1 | Pixel-clock enable, high on alternate master cycles |
| frame_valid | output | 1 | Frame-valid window |
| line_valid | output | 1 | Active columns of an active row |
| frame_start | output | 1 | One-cycle marker on the rise of frame-valid |
| row_cnt | output | RCNT_W | Row index within the frame |
| col_cnt | output | UNIT_W | Column unit index within the row |

## Verification
Every strobe is decoded from the counter state. A fault in the unit, column or row counter therefore shows up within the frame it happens in: the frame length, the frame-valid span, the line-valid total or the frame-start offset will be wrong. A wrong captured overhead, clamp or row total shifts the frame-start offset before frame-valid even opens. Capturing the configuration at the wrong moment corrupts the frame in which the inputs changed, because each measured frame is compared against the values that were present at its start. The bench therefore changes the configuration early in every frame.

// File: rtl/ft_pkg.sv
// Shared constants, the dark-column mode encoding and the overhead lookup
// for the frame timing generator. Purely declarative; holds no state.
package ft_pkg;

    // Smallest horizontal blanking the row logic accepts, in units.
    localparam int unsigned HBLANK_FLOOR = 9;

    // Units of frame-valid guard before the first and after the last active column.
    localparam int unsigned EDGE_UNITS   = 6;

    // Fixed blanking overhead for each dark-column option, in units.
    localparam int unsigned OVH_NONE     = 107;
    localparam int unsigned OVH_EIGHT    = 113;
    localparam int unsigned OVH_SIXTEEN  = 121;

    // Dark-column mode encoding; the top bit alone selects sixteen columns.
    typedef enum logic [1:0] {
        DARK_NONE      = 2'b00,
        DARK_EIGHT     = 2'b01,
        DARK_SIXTEEN   = 2'b10,
        DARK_SIXTEEN_B = 2'b11
    } dark_mode_e;

    // Return the blanking overhead, in units, for a dark-column mode.
    function automatic int unsigned dark_overhead(input dark_mode_e mode);
        int unsigned ovh;
        case (mode)
            DARK_NONE:  ovh = OVH_NONE;
            DARK_EIGHT: ovh = OVH_EIGHT;
            default:    ovh = OVH_SIXTEEN;
        endcase
        return ovh;
    endfunction

endpackage

// File: rtl/ft_cfg_latch.sv
// Configuration shadow for the frame timing generator.
// It captures the static configuration inputs and turns them into the
// per-frame limits that the counters and the strobe decoder use.
// Assumes: load is high only on the last master cycle of a frame.
// Assumes: UNIT_W and RCNT_W are wide enough for the largest row and frame.
module ft_cfg_latch
    import ft_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 10,
    parameter int HB_W   = 10,
    parameter int VB_W   = 10,
    parameter int MULT_W = 4,
    parameter int INT_W  = 12,
    parameter int UNIT_W = 12,
    parameter int RCNT_W = 14,
    parameter int SUB_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [HB_W-1:0]   cfg_hblank,
    input  logic [VB_W-1:0]   cfg_vblank,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [1:0]        cfg_dark,
    input  logic [INT_W-1:0]  cfg_integ,
    output logic [SUB_W-1:0]  unit_last,
    output logic [UNIT_W-1:0] row_last,
    output logic [UNIT_W-1:0] blank_units,
    output logic [UNIT_W-1:0] fv_on_col,
    output logic [RCNT_W-1:0] act_last_row,
    output logic [RCNT_W-1:0] frame_last_row
);

    logic [UNIT_W-1:0] hb_eff;
    logic [UNIT_W-1:0] ovh;
    logic [UNIT_W-1:0] q_next;
    logic [UNIT_W-1:0] row_last_next;
    logic [UNIT_W-1:0] fv_on_next;
    logic [RCNT_W-1:0] rows_next;
    logic [RCNT_W-1:0] normal_rows;
    logic [RCNT_W-1:0] integ_ext;
    logic [RCNT_W-1:0] frame_last_next;
    logic [SUB_W-1:0]  unit_last_next;

    // Derive the row and frame limits from the raw inputs.
    always_comb begin
        hb_eff          = (UNIT_W'(cfg_hblank) < UNIT_W'(HBLANK_FLOOR))
                          ? UNIT_W'(HBLANK_FLOOR) : UNIT_W'(cfg_hblank);
        ovh             = UNIT_W'(dark_overhead(dark_mode_e'(cfg_dark)));
        q_next          = ovh + hb_eff;
        row_last_next   = q_next + UNIT_W'(cfg_cols);
        fv_on_next      = q_next - UNIT_W'(EDGE_UNITS);
        rows_next       = RCNT_W'(cfg_rows);
        normal_rows     = rows_next + RCNT_W'(cfg_vblank) + RCNT_W'(2);
        integ_ext       = RCNT_W'(cfg_integ);
        frame_last_next = (integ_ext >= normal_rows) ? integ_ext
                                                     : normal_rows - RCNT_W'(1);
        unit_last_next  = SUB_W'(cfg_mult) + SUB_W'(1);
    end

    // Capture the limits during reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            unit_last      <= unit_last_next;
            row_last       <= row_last_next;
            blank_units    <= q_next;
            fv_on_col      <= fv_on_next;
            act_last_row   <= rows_next;
            frame_last_row <= frame_last_next;
        end
    end

endmodule

// File: rtl/ft_counters.sv
// Position counters for the frame timing generator.
// A sub-unit counter divides the master clock into column units. A column
// counter walks the row and a row counter walks the frame. A free-running
// toggle provides the pixel-clock enable.
// Assumes: the limits are stable except on the cycle frame_wrap is high.
module ft_counters #(
    parameter int UNIT_W = 12,
    parameter int RCNT_W = 14,
    parameter int SUB_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SUB_W-1:0]  unit_last,
    input  logic [UNIT_W-1:0] row_last,
    input  logic [RCNT_W-1:0] frame_last_row,
    output logic [UNIT_W-1:0] col,
    output logic [RCNT_W-1:0] row,
    output logic              unit_first,
    output logic              frame_wrap,
    output logic              pclk_en
);

    logic [SUB_W-1:0] sub_q;
    logic             unit_end;
    logic             row_end;

    assign unit_end   = (sub_q == unit_last);
    assign row_end    = unit_end && (col == row_last);
    assign frame_wrap = row_end && (row == frame_last_row);
    assign unit_first = (sub_q == '0);

    // Count master cycles inside one column unit.
    always_ff @(posedge clk) begin
        if (!rst_n)        sub_q <= '0;
        else if (unit_end) sub_q <= '0;
        else               sub_q <= sub_q + SUB_W'(1);
    end

    // Advance the column unit index and wrap it at the end of the row.
    always_ff @(posedge clk) begin
        if (!rst_n)        col <= '0;
        else if (row_end)  col <= '0;
        else if (unit_end) col <= col + UNIT_W'(1);
    end

    // Advance the row index and wrap it at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          row <= '0;
        else if (frame_wrap) row <= '0;
        else if (row_end)    row <= row + RCNT_W'(1);
    end

    // Halve the master clock to form the pixel-clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) pclk_en <= 1'b0;
        else        pclk_en <= ~pclk_en;
    end

endmodule

// File: rtl/ft_strobes.sv
// Strobe decoder for the frame timing generator.
// It turns the scan position and the captured limits into frame-valid,
// line-valid and the frame-start marker. Purely combinational.
// Assumes: the frame has at least act_last_row + 2 rows, so the
// frame-valid tail row always exists.
module ft_strobes
    import ft_pkg::*;
#(
    parameter int UNIT_W = 12,
    parameter int RCNT_W = 14
) (
    input  logic [UNIT_W-1:0] col,
    input  logic [RCNT_W-1:0] row,
    input  logic              unit_first,
    input  logic [UNIT_W-1:0] fv_on_col,
    input  logic [UNIT_W-1:0] blank_units,
    input  logic [RCNT_W-1:0] act_last_row,
    output logic              frame_valid,
    output logic              line_valid,
    output logic              frame_start
);

    logic head_row;
    logic body_row;
    logic tail_row;
    logic act_row;

    // Classify the current row against the active region.
    always_comb begin
        head_row = (row == '0);
        act_row  = (row <= act_last_row);
        body_row = !head_row && act_row;
        tail_row = (row == act_last_row + RCNT_W'(1));
    end

    // Decode the strobes from the position within the row.
    always_comb begin
        frame_valid = (head_row && (col >= fv_on_col))
                   || body_row
                   || (tail_row && (col < UNIT_W'(EDGE_UNITS)));
        line_valid  = act_row && (col >= blank_units);
        frame_start = head_row && (col == fv_on_col) && unit_first;
    end

endmodule

// File: rtl/frame_timing_gen.sv
// Top of the programmable frame timing generator.
// It wires the configuration shadow, the position counters and the strobe
// decoder together. The configuration shadow reloads on the cycle in which
// the counters wrap the frame.
// Assumes: the configuration inputs are static inputs of the master clock domain.
module frame_timing_gen #(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 10,
    parameter int HB_W   = 10,
    parameter int VB_W   = 10,
    parameter int MULT_W = 4,
    parameter int INT_W  = 12,
    localparam int UNIT_W = ((COL_W > HB_W) ? COL_W : HB_W) + 2,
    localparam int RV_W   = (ROW_W > VB_W) ? ROW_W : VB_W,
    localparam int RCNT_W = ((RV_W > INT_W) ? RV_W : INT_W) + 2,
    localparam int SUB_W  = MULT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [HB_W-1:0]   cfg_hblank,
    input  logic [VB_W-1:0]   cfg_vblank,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [1:0]        cfg_dark,
    input  logic [INT_W-1:0]  cfg_integ,
    output logic              pclk_en,
    output logic              frame_valid,
    output logic              line_valid,
    output logic              frame_start,
    output logic [RCNT_W-1:0] row_cnt,
    output logic [UNIT_W-1:0] col_cnt
);

    logic [SUB_W-1:0]  unit_last;
    logic [UNIT_W-1:0] row_last;
    logic [UNIT_W-1:0] blank_units;
    logic [UNIT_W-1:0] fv_on_col;
    logic [RCNT_W-1:0] act_last_row;
    logic [RCNT_W-1:0] frame_last_row;
    logic              unit_first;
    logic              frame_wrap;

    ft_cfg_latch #(
        .COL_W (COL_W),  .ROW_W (ROW_W),  .HB_W  (HB_W),
        .VB_W  (VB_W),   .MULT_W(MULT_W), .INT_W (INT_W),
        .UNIT_W(UNIT_W), .RCNT_W(RCNT_W), .SUB_W (SUB_W)
    ) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (frame_wrap),
        .cfg_cols      (cfg_cols),
        .cfg_rows      (cfg_rows),
        .cfg_hblank    (cfg_hblank),
        .cfg_vblank    (cfg_vblank),
        .cfg_mult      (cfg_mult),
        .cfg_dark      (cfg_dark),
        .cfg_integ     (cfg_integ),
        .unit_last     (unit_last),
        .row_last      (row_last),
        .blank_units   (blank_units),
        .fv_on_col     (fv_on_col),
        .act_last_row  (act_last_row),
        .frame_last_row(frame_last_row)
    );

    ft_counters #(
        .UNIT_W(UNIT_W), .RCNT_W(RCNT_W), .SUB_W(SUB_W)
    ) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .unit_last     (unit_last),
        .row_last      (row_last),
        .frame_last_row(frame_last_row),
        .col           (col_cnt),
        .row           (row_cnt),
        .unit_first    (unit_first),
        .frame_wrap    (frame_wrap),
        .pclk_en       (pclk_en)
    );

    ft_strobes #(
        .UNIT_W(UNIT_W), .RCNT_W(RCNT_W)
    ) u_strb (
        .col         (col_cnt),
        .row         (row_cnt),
        .unit_first  (unit_first),
        .fv_on_col   (fv_on_col),
        .blank_units (blank_units),
        .act_last_row(act_last_row),
        .frame_valid (frame_valid),
        .line_valid  (line_valid),
        .frame_start (frame_start)
    );

endmodule

// File: rtl/ft_checker.sv
// Protocol checker for the frame timing generator. It observes only the top
// ports and is attached to every instance through the bind below.
module ft_checker #(
    parameter int UNIT_W = 12,
    parameter int RCNT_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pclk_en,
    input logic              frame_valid,
    input logic              line_valid,
    input logic              frame_start,
    input logic [RCNT_W-1:0] row_cnt,
    input logic [UNIT_W-1:0] col_cnt
);

    assert_pclk_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pclk_en != $past(pclk_en)));

    assert_fv_on_unit_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid != $past(frame_valid)) |-> (col_cnt != $past(col_cnt)));

    assert_lv_inside_fv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid);

    assert_fs_marks_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (frame_valid && !$past(frame_valid)));

    assert_rise_has_fs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !$past(frame_valid)) |-> frame_start);

    assert_col_steps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (col_cnt != $past(col_cnt)) |->
            ((col_cnt == $past(col_cnt) + UNIT_W'(1)) || (col_cnt == '0)));

    assert_row_at_col_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (row_cnt != $past(row_cnt)) |-> (col_cnt == '0));

endmodule

bind frame_timing_gen ft_checker #(
    .UNIT_W(UNIT_W), .RCNT_W(RCNT_W)
) u_ft_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pclk_en    (pclk_en),
    .frame_valid(frame_valid),
    .line_valid (line_valid),
    .frame_start(frame_start),
    .row_cnt    (row_cnt),
    .col_cnt    (col_cnt)
);

// File: tb/test_frame_timing_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one predicted frame per configuration,
// and the monitor measures each frame at the ports and compares it.
module test_frame_timing_gen;

    localparam int COL_W  = 10;
    localparam int ROW_W  = 10;
    localparam int HB_W   = 10;
    localparam int VB_W   = 10;
    localparam int MULT_W = 4;
    localparam int INT_W  = 12;
    localparam int UNIT_W = ((COL_W > HB_W) ? COL_W : HB_W) + 2;
    localparam int RV_W   = (ROW_W > VB_W) ? ROW_W : VB_W;
    localparam int RCNT_W = ((RV_W > INT_W) ? RV_W : INT_W) + 2;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic [COL_W-1:0]  cfg_cols   = '0;
    logic [ROW_W-1:0]  cfg_rows   = '0;
    logic [HB_W-1:0]   cfg_hblank = '0;
    logic [VB_W-1:0]   cfg_vblank = '0;
    logic [MULT_W-1:0] cfg_mult   = '0;
    logic [1:0]        cfg_dark   = '0;
    logic [INT_W-1:0]  cfg_integ  = '0;
    logic              pclk_en;
    logic              frame_valid;
    logic              line_valid;
    logic              frame_start;
    logic [RCNT_W-1:0] row_cnt;
    logic [UNIT_W-1:0] col_cnt;

    always #10 clk = ~clk;

    frame_timing_gen #(
        .COL_W(COL_W), .ROW_W(ROW_W), .HB_W(HB_W),
        .VB_W(VB_W), .MULT_W(MULT_W), .INT_W(INT_W)
    ) i_frame_timing_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_cols(cfg_cols), .cfg_rows(cfg_rows), .cfg_hblank(cfg_hblank),
        .cfg_vblank(cfg_vblank), .cfg_mult(cfg_mult), .cfg_dark(cfg_dark),
        .cfg_integ(cfg_integ),
        .pclk_en(pclk_en), .frame_valid(frame_valid), .line_valid(line_valid),
        .frame_start(frame_start), .row_cnt(row_cnt), .col_cnt(col_cnt)
    );

    typedef struct {
        int cols; int rows; int hb; int vb; int mult; int dark; int integ;
    } cfg_t;

    typedef struct {
        int total; int fv; int lv; int lines; int fs_off; int col_max; int row_max;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    event frame_ev;

    task automatic check(input string what, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Frame figures predicted from the requirements alone.
    function automatic exp_t predict(cfg_t c);
        exp_t e;
        int k, hbe, q, r, nrows, m;
        k     = (c.dark >= 2) ? 121 : ((c.dark == 1) ? 113 : 107);   // R4
        hbe   = (c.hb < 9) ? 9 : c.hb;                               // R5
        q     = k + hbe;
        r     = c.cols + 1 + q;                                      // R3
        nrows = (c.integ >= c.rows + c.vb + 2) ? c.integ + 1
                                               : c.rows + c.vb + 2;  // R6
        m     = c.mult + 2;
        e.total   = nrows * r * m;
        e.fv      = ((c.rows + 1) * r - q + 12) * m;                 // R7
        e.lv      = (c.rows + 1) * (c.cols + 1) * m;                 // R8
        e.lines   = c.rows + 1;
        e.fs_off  = (q - 6) * m;                                     // R9
        e.col_max = r - 1;                                           // R11
        e.row_max = nrows - 1;
        return e;
    endfunction

    task automatic apply(cfg_t c);
        cfg_cols   = COL_W'(c.cols);
        cfg_rows   = ROW_W'(c.rows);
        cfg_hblank = HB_W'(c.hb);
        cfg_vblank = VB_W'(c.vb);
        cfg_mult   = MULT_W'(c.mult);
        cfg_dark   = 2'(c.dark);
        cfg_integ  = INT_W'(c.integ);
    endtask

    // Driver: reset checks, then one new configuration early in every frame (R10).
    initial begin
        cfg_t base;
        cfg_t seq [7];
        base   = '{7, 3, 9, 1, 0, 1, 0};
        seq[0] = '{7, 3, 20, 2, 1, 0, 0};   // no dark columns, multiplier 1
        seq[1] = '{5, 2, 3, 0, 0, 2, 0};    // hblank clamped, sixteen dark
        seq[2] = '{5, 2, 9, 0, 0, 3, 10};   // alternate sixteen code, long integration
        seq[3] = '{7, 3, 9, 1, 0, 1, 6};    // integration equal to row total
        seq[4] = '{7, 3, 9, 1, 0, 1, 5};    // integration just below row total
        seq[5] = '{15, 1, 0, 3, 3, 1, 2};   // zero hblank, odd unit length
        seq[6] = '{7, 3, 9, 1, 0, 1, 0};
        apply(base);
        repeat (3) @(negedge clk);
        check("R1 frame_valid in reset", frame_valid, 0);
        check("R1 line_valid in reset", line_valid, 0);
        check("R1 frame_start in reset", frame_start, 0);
        check("R1 pclk_en in reset", pclk_en, 0);
        check("R1 row_cnt in reset", row_cnt, 0);
        check("R1 col_cnt in reset", col_cnt, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 pclk_en phase", pclk_en, (i % 2 == 0) ? 1 : 0);
        end
        exp_q.push_back(predict(base));
        for (int i = 0; i < 7; i++) begin
            @(frame_ev);
            apply(seq[i]);
            exp_q.push_back(predict(seq[i]));
        end
        while (exp_q.size() != 0) @(negedge clk);
        finish_run();
    end

    // Monitor: measure each frame between boundaries and compare with the scoreboard.
    int prev_row = 0, prev_col = 0;
    bit prev_ok = 1'b0, measuring = 1'b0, prev_lv = 1'b0;
    int a_cyc, a_fv, a_lv, a_lines, a_fs, a_fs_off, a_out, a_colmax, a_rowmax;

    task automatic close_frame();
        exp_t e;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        check("R3 R4 R5 R6 R10 frame length", a_cyc, e.total);
        check("R7 frame_valid cycles", a_fv, e.fv);
        check("R8 line_valid cycles", a_lv, e.lv);
        check("R8 line count", a_lines, e.lines);
        check("R8 line_valid outside frame_valid", a_out, 0);
        check("R9 frame_start pulses", a_fs, 1);
        check("R9 frame_start offset", a_fs_off, e.fs_off);
        check("R11 last column index", a_colmax, e.col_max);
        check("R11 last row index", a_rowmax, e.row_max);
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ok   = 1'b0;
            measuring = 1'b0;
        end else begin
            if (prev_ok && row_cnt == 0 && col_cnt == 0 && !(prev_row == 0 && prev_col == 0)) begin
                if (measuring) close_frame();
                measuring = 1'b1;
                a_cyc = 0; a_fv = 0; a_lv = 0; a_lines = 0; a_fs = 0;
                a_fs_off = -1; a_out = 0; a_colmax = 0; a_rowmax = 0;
                -> frame_ev;
            end
            if (measuring) begin
                if (frame_start) begin
                    a_fs++;
                    a_fs_off = a_cyc;
                end
                a_cyc++;
                if (frame_valid) a_fv++;
                if (line_valid) a_lv++;
                if (line_valid && !prev_lv) a_lines++;
                if (line_valid && !frame_valid) a_out++;
                if (int'(col_cnt) > a_colmax) a_colmax = int'(col_cnt);
                if (int'(row_cnt) > a_rowmax) a_rowmax = int'(row_cnt);
            end
            prev_row = int'(row_cnt);
            prev_col = int'(col_cnt);
            prev_lv  = line_valid;
            prev_ok  = 1'b1;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R6: actual 150000 cycles expected completion before that");
        finish_run();
    end

endmodule